// File: doc/BRIEF.md
# Idle Link Pulse Generator

This block produces the normal link pulses that a 10 Mb/s twisted-pair transmitter puts on an idle line. It runs from the 10 MHz bit clock, so one clock cycle is one bit time. An interval timer counts idle cycles. Each time the timer expires, the block raises a one-cycle pulse request to the line driver. The pulse shape is set by the analog driver, which is not part of this block.

The timer does not run on a free schedule. It goes back to zero whenever the transmitter reports that it has completed an end-of-frame sequence. It is held at zero for as long as the transmitter is busy. A pulse therefore appears only after a full interval of silence, counted from the last frame or from the last earlier pulse. The interval defaults to 160,000 cycles, which is 16 ms at 10 MHz. It is a parameter, so a simulation can use a short value.

Top module: `idle_link_pulse_gen`

## Requirements
- R1: While `rst_n` is low, `link_pulse` is low at every clock edge. After reset is released, the first pulse is high at the INTERVAL-th rising clock edge, and not earlier.
- R2: Every pulse is high for exactly one clock cycle (one bit time).
- R3: With `tx_active` and `eof_done` both held low, consecutive pulses rise exactly INTERVAL clock edges apart.
- R4: After a clock edge at which `eof_done` is sampled high, the next pulse is high at the INTERVAL-th following edge, with no pulse in between.
- R5: `link_pulse` is never high at the edge that follows an edge where `tx_active` was sampled high. Once `tx_active` falls, the next pulse comes INTERVAL edges after the last edge at which it was high.
- R6: If `eof_done` or `tx_active` is high at the edge where the timer would expire, that pulse is dropped and a full new interval starts.
- R7: An assertion of reset in the middle of an interval clears the timer. The next pulse follows R1 again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 10 MHz bit clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tx_active | input | 1 | High while a frame is being transmitted |
| eof_done | input | 1 | One-cycle strobe when an end-of-frame sequence has been sent |
| link_pulse | output | 1 | Registered link pulse request, high for one cycle |

## Verification
The bench measures the exact edge count from each restart cause to the following pulse. A design that is off by one in the terminal count, or that restarts at one instead of zero, shows up as a gap of 19 or 21 instead of 20. It drives `eof_done` and `tx_active` into the very cycle in which the timer expires. A design that checks expiry before the restart would leak a pulse in the middle of traffic, and the bench sees it. It also holds `tx_active` high far longer than one interval to catch a timer that keeps counting while the line is busy. It resets the block part-way through an interval to catch a counter that keeps its old value.

// File: rtl/lpg_pkg.sv
// Package: shared types for the idle link pulse generator.
// Assumes: one clock cycle equals one bit time.
package lpg_pkg;

    // What the timer does on the coming clock edge.
    typedef enum logic [1:0] {
        TMR_COUNT   = 2'b00,  // advance by one
        TMR_RESTART = 2'b01,  // clear because a frame just ended
        TMR_HOLD    = 2'b10   // clear and hold because transmission is active
    } tmr_cmd_e;

    // Default interval: 16 ms at a 10 MHz bit clock.
    localparam int unsigned DEFAULT_INTERVAL = 160000;

endpackage

// File: rtl/lpg_restart_ctrl.sv
// Module: lpg_restart_ctrl
// Turns the transmitter status into one command for the interval timer.
// Assumes: eof_done is a single-cycle strobe. tx_active may stay high for any length of time.
// Hold takes priority over restart. Both clear the timer.
module lpg_restart_ctrl
    import lpg_pkg::*;
(
    input  logic     tx_active,
    input  logic     eof_done,
    output tmr_cmd_e cmd,
    output logic     block_pulse
);

    // Pick the timer command from the transmitter status.
    always_comb begin
        if (tx_active) begin
            cmd = TMR_HOLD;
        end else if (eof_done) begin
            cmd = TMR_RESTART;
        end else begin
            cmd = TMR_COUNT;
        end
    end

    // Any activity on the transmit side blocks a pulse in this cycle.
    always_comb begin
        block_pulse = (cmd != TMR_COUNT);
    end

endmodule

// File: rtl/lpg_interval_timer.sv
// Module: lpg_interval_timer
// Counts idle bit times from 0 to INTERVAL-1, then wraps to 0.
// Assumes: INTERVAL >= 2. Synchronous active-low reset clears the count.
// The expiry flag is combinational and is high while the count is at INTERVAL-1.
module lpg_interval_timer
    import lpg_pkg::*;
#(
    parameter int unsigned INTERVAL = DEFAULT_INTERVAL
) (
    input  logic     clk,
    input  logic     rst_n,
    input  tmr_cmd_e cmd,
    output logic     expire
);

    localparam int unsigned CW = (INTERVAL > 2) ? $clog2(INTERVAL) : 1;
    localparam logic [CW-1:0] LAST = CW'(INTERVAL - 1);

    logic [CW-1:0] count_q;

    // Flag the final count of the interval.
    always_comb begin
        expire = (count_q == LAST);
    end

    // Advance, wrap, or clear the idle count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (cmd != TMR_COUNT) begin
            count_q <= '0;
        end else if (expire) begin
            count_q <= '0;
        end else begin
            count_q <= count_q + 1'b1;
        end
    end

endmodule

// File: rtl/lpg_pulse_reg.sv
// Module: lpg_pulse_reg
// Registers the pulse request so the line driver sees a clean, glitch-free level.
// Assumes: fire is high for at most one cycle per interval.
module lpg_pulse_reg (
    input  logic clk,
    input  logic rst_n,
    input  logic fire,
    output logic pulse
);

    logic pulse_q;

    // Capture the request for exactly one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pulse_q <= 1'b0;
        end else begin
            pulse_q <= fire;
        end
    end

    // Drive the output straight from the flop.
    always_comb begin
        pulse = pulse_q;
    end

endmodule

// File: rtl/idle_link_pulse_gen.sv
// Module: idle_link_pulse_gen (top)
// Emits one-bit-time link pulses after each full interval of transmit silence.
// Assumes: clk is the bit clock and rst_n is synchronous and active low.
// A pulse is dropped if the transmitter is busy, or has just finished a frame, in the expiry cycle.
module idle_link_pulse_gen
    import lpg_pkg::*;
#(
    parameter int unsigned INTERVAL = DEFAULT_INTERVAL
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tx_active,
    input  logic eof_done,
    output logic link_pulse
);

    tmr_cmd_e cmd;
    logic     block_pulse;
    logic     expire;
    logic     fire;

    lpg_restart_ctrl u_ctrl (
        .tx_active   (tx_active),
        .eof_done    (eof_done),
        .cmd         (cmd),
        .block_pulse (block_pulse)
    );

    lpg_interval_timer #(
        .INTERVAL (INTERVAL)
    ) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .cmd    (cmd),
        .expire (expire)
    );

    // Fire only when the timer expires on an idle line.
    always_comb begin
        fire = expire && !block_pulse;
    end

    lpg_pulse_reg u_out (
        .clk   (clk),
        .rst_n (rst_n),
        .fire  (fire),
        .pulse (link_pulse)
    );

endmodule

// File: rtl/idle_link_pulse_gen_chk.sv
// Module: idle_link_pulse_gen_chk
// Checker bound to the top module. It keeps its own count of edges since the
// last restart, pulse or reset, and compares the output against that count.
module idle_link_pulse_gen_chk #(
    parameter int unsigned INTERVAL = 160000
) (
    input logic clk,
    input logic rst_n,
    input logic tx_active,
    input logic eof_done,
    input logic link_pulse
);

    localparam int unsigned GW = $clog2(INTERVAL + 1);
    localparam logic [GW-1:0] FULL = GW'(INTERVAL);

    logic [GW-1:0] gap_q;

    // Track edges since the last event that starts a new interval.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap_q <= '0;
        end else if (tx_active || eof_done) begin
            gap_q <= '0;
        end else if (gap_q == FULL) begin
            gap_q <= GW'(1);
        end else begin
            gap_q <= gap_q + 1'b1;
        end
    end

    assert_single_cycle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        link_pulse |=> !link_pulse);

    assert_quiet_during_tx_R5: assert property (@(posedge clk) disable iff (!rst_n)
        tx_active |=> !link_pulse);

    assert_no_pulse_after_eof_R6: assert property (@(posedge clk) disable iff (!rst_n)
        eof_done |=> !link_pulse);

    assert_pulse_only_at_interval_R3: assert property (@(posedge clk) disable iff (!rst_n)
        link_pulse |-> (gap_q == FULL));

    assert_interval_always_pulses_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (gap_q == FULL) |-> link_pulse);

endmodule

bind idle_link_pulse_gen idle_link_pulse_gen_chk #(
    .INTERVAL (INTERVAL)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tx_active  (tx_active),
    .eof_done   (eof_done),
    .link_pulse (link_pulse)
);

// File: tb/test_idle_link_pulse_gen.sv
// Directed bench for idle_link_pulse_gen with a short interval.
module test_idle_link_pulse_gen;

    localparam int IV = 20;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tx_active = 1'b0;
    logic eof_done = 1'b0;
    logic link_pulse;

    int total = 0;
    int bad = 0;

    idle_link_pulse_gen #(.INTERVAL(IV)) i_idle_link_pulse_gen (
        .clk        (clk),
        .rst_n      (rst_n),
        .tx_active  (tx_active),
        .eof_done   (eof_done),
        .link_pulse (link_pulse)
    );

    always #5 clk = ~clk;

    // Record one check and report a mismatch.
    task automatic check(input string req, input int actual, input int expected);
        total++;
        if (actual != expected) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, actual, expected);
        end
    endtask

    // Count edges until the pulse is seen high; -1 if none within three intervals.
    task automatic measure(output int gap);
        gap = -1;
        for (int i = 1; i <= 3 * IV; i++) begin
            @(posedge clk);
            @(negedge clk);
            if (link_pulse) begin
                gap = i;
                break;
            end
        end
    endtask

    // Advance n edges and count how many of them showed a pulse.
    task automatic idle_edges(input int n, output int seen);
        seen = 0;
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
            if (link_pulse) seen++;
        end
    endtask

    // Apply the strobes for one edge, then clear them; returns the output after that edge.
    task automatic one_edge(input logic eof, input logic tx, output logic out);
        eof_done = eof;
        tx_active = tx;
        @(posedge clk);
        @(negedge clk);
        out = link_pulse;
        eof_done = 1'b0;
        tx_active = 1'b0;
    endtask

    task automatic test_reset_and_first;
        int seen;
        int gap;
        rst_n = 1'b0;
        idle_edges(3, seen);
        check("R1 low in reset", seen, 0);
        rst_n = 1'b1;
        measure(gap);
        check("R1 first pulse edge", gap, IV);
    endtask

    task automatic test_periodic;
        int gap;
        int seen;
        idle_edges(1, seen);
        check("R2 pulse width one cycle", seen, 0);
        measure(gap);
        check("R3 period", gap + 1, IV);
        measure(gap);
        check("R3 period again", gap, IV);
    endtask

    task automatic test_eof_restart;
        int gap;
        int seen;
        logic out;
        idle_edges(7, seen);
        check("R4 no pulse mid interval", seen, 0);
        one_edge(1'b1, 1'b0, out);
        check("R4 no pulse on eof edge", int'(out), 0);
        measure(gap);
        check("R4 gap after eof", gap, IV);
    endtask

    task automatic test_tx_hold;
        int seen;
        int gap;
        tx_active = 1'b1;
        idle_edges(3 * IV, seen);
        check("R5 no pulse while tx active", seen, 0);
        tx_active = 1'b0;
        measure(gap);
        check("R5 gap after tx falls", gap, IV);
    endtask

    task automatic test_restart_at_expiry;
        int seen;
        int gap;
        logic out;
        idle_edges(IV - 1, seen);
        check("R6 quiet before expiry", seen, 0);
        one_edge(1'b1, 1'b0, out);
        check("R6 eof at expiry drops pulse", int'(out), 0);
        measure(gap);
        check("R6 gap after eof at expiry", gap, IV);
        idle_edges(IV - 1, seen);
        check("R6 quiet before second expiry", seen, 0);
        one_edge(1'b0, 1'b1, out);
        check("R6 tx at expiry drops pulse", int'(out), 0);
        measure(gap);
        check("R6 gap after tx at expiry", gap, IV);
    endtask

    task automatic test_reset_midway;
        int seen;
        int gap;
        idle_edges(9, seen);
        rst_n = 1'b0;
        idle_edges(IV + 2, seen);
        check("R7 low during mid reset", seen, 0);
        rst_n = 1'b1;
        measure(gap);
        check("R7 gap after mid reset", gap, IV);
    endtask

    initial begin
        #2_000_000;
        total++;
        bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        @(negedge clk);
        test_reset_and_first();
        test_periodic();
        test_eof_restart();
        test_tx_hold();
        test_restart_at_expiry();
        test_reset_midway();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule